// File: doc/BRIEF.md
# I2C Data Port Buffer

This block is the byte store that sits between a controller's 16-bit data register and its bus-side transfer sequencer. It holds up to four bytes in one shared buffer. It keeps separate counts of bytes waiting to be sent and bytes received. The host writes 16-bit halves or a single final byte. The sequencer takes transmit bytes, highest filled lane first, and deposits received bytes from lane 0 upward. A byte-order input decides which byte of a 16-bit host word maps to which buffer lane.

Every host access also produces one-cycle pulses on a set of flag-update outputs. The interrupt and status logic downstream applies them: clear the receive-ready and receive-overrun flags, clear the transmit-ready and transmit-underflow flags, set the single-byte-read flag, and set access-ready while leaving master mode. A final pulse tells the sequencer to resume. The bus protocol engine and the interrupt logic are outside this block.

Top module: `i2c_dport_buf`

## Requirements
- R1: During and after reset, with no access, `tx_count` and `rx_count` are 0, `host_rdata` is 0, `tx_byte` is 0 and every pulse output is 0.
- R2: A 16-bit write with `host_wr=1`, `host_wr_byte=0` and at most DEPTH-2 transmit bytes held adds two bytes and increases `tx_count` by 2. With `byte_order=1`, `host_wdata[15:8]` goes to lane 1 and `[7:0]` to lane 0; with `byte_order=0` the halves are swapped. Earlier bytes move up two lanes.
- R3: `tx_byte` shows lane `tx_count-1`, or 0 when `tx_count` is 0. A `tx_pop` with a non-zero count decrements `tx_count`, so bytes leave from the highest filled lane downward. A pop at count 0 is ignored.
- R4: An 8-bit write (`host_wr=1`, `host_wr_byte=1`) with fewer than DEPTH bytes held loads `host_wdata[7:0]` into lane 0, moves earlier bytes up one lane and increases `tx_count` by 1.
- R5: A 16-bit write with more than DEPTH-2 bytes held, or an 8-bit write with DEPTH bytes held, leaves `tx_count` and the buffer unchanged.
- R6: An `rx_push` stores `rx_byte` in lane `rx_count` and increments `rx_count`. Received bytes therefore fill lanes upward from lane 0. A push with DEPTH bytes held is ignored.
- R7: A read (`host_rd=1`) with two or more received bytes returns {lane0,lane1} on `host_rdata[15:8]`/`[7:0]` when `byte_order=1`, and {lane1,lane0} when it is 0. It consumes two bytes, and the remaining bytes shift down two lanes.
- R8: A read with one byte held returns lane 0 in the upper half (`byte_order=1`) or the lower half (`byte_order=0`), with 0 in the other half. It pulses `set_sbd` and empties the receive count. A read with nothing held returns 0 and does not pulse `set_sbd`.
- R9: Every read pulses `clr_rrdy` and `clr_rovr`. When `master_mode=1` and `recv_mode=1`, the read also pulses `set_ardy` and `clr_mst`.
- R10: Every write, accepted or ignored, pulses `clr_xudf` and `clr_xrdy`, and no read pulse.
- R11: Every host access, read or write, is followed by a single one-cycle `kick` pulse. No kick is produced without an access.
- R12: In a cycle with a host access, `tx_pop` and `rx_push` are ignored. When `host_rd` and `host_wr` are both high, the read is done and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_order | input | 1 | Lane mapping of 16-bit host words |
| master_mode | input | 1 | Controller is bus master |
| recv_mode | input | 1 | Controller is receiving |
| host_rd | input | 1 | Data register read strobe |
| host_wr | input | 1 | Data register write strobe |
| host_wr_byte | input | 1 | Write is 8-bit (final byte) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Data of last read, registered |
| tx_pop | input | 1 | Sequencer takes one transmit byte |
| tx_byte | output | 8 | Next transmit byte |
| tx_count | output | CNT_W | Transmit bytes held |
| rx_push | input | 1 | Sequencer delivers one byte |
| rx_byte | input | 8 | Received byte |
| rx_count | output | CNT_W | Received bytes held |
| clr_rrdy | output | 1 | Pulse: clear receive-ready |
| clr_rovr | output | 1 | Pulse: clear receive-overrun |
| set_ardy | output | 1 | Pulse: set access-ready |
| clr_mst | output | 1 | Pulse: leave master mode |
| set_sbd | output | 1 | Pulse: single-byte read |
| clr_xudf | output | 1 | Pulse: clear transmit-underflow |
| clr_xrdy | output | 1 | Pulse: clear transmit-ready |
| kick | output | 1 | Pulse: sequencer may continue |

## Verification
All state, `host_rdata` and every pulse come from registers loaded at the clock edge that samples a strobe. Each of them is therefore due exactly one cycle after the stimulus. `tx_byte` follows combinationally from the updated counters. The bench drives a strobe on a falling edge and removes it on the next falling edge, then compares all results there, half a cycle after the only edge that could change them. The sweeps cover both byte orders, every fill level from empty to full plus an overflow attempt, and all four master/receive combinations.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR16 = 2'd2,
        OP_WR8  = 2'd3
    } host_op_e;

    typedef struct packed {
        logic clr_rrdy;
        logic clr_rovr;
        logic set_ardy;
        logic clr_mst;
        logic set_sbd;
        logic clr_xudf;
        logic clr_xrdy;
        logic kick;
    } flag_pulse_t;

    // read wins over write; width qualifier only matters for writes
    function automatic host_op_e decode_op(input logic rd, input logic wr, input logic wr_byte);
        if (rd)
            return OP_RD;
        else if (wr)
            return wr_byte ? OP_WR8 : OP_WR16;
        else
            return OP_IDLE;
    endfunction

    // returns {lane1, lane0} for a 16-bit host write
    function automatic half_t pack_write(input half_t v, input logic order);
        return order ? v : {v[BYTE_W-1:0], v[HALF_W-1:BYTE_W]};
    endfunction

    // returns the 16-bit read value from the two lowest lanes
    function automatic half_t format_read(input byte_t l0, input byte_t l1,
                                          input logic two, input logic one,
                                          input logic order);
        if (two)
            return order ? {l0, l1} : {l1, l0};
        else if (one)
            return order ? {l0, byte_t'(0)} : {byte_t'(0), l0};
        else
            return half_t'(0);
    endfunction

endpackage

// File: rtl/dpb_lanes.sv
module dpb_lanes
    import dpb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  host_op_e         op,
    input  half_t            wpacked,
    input  byte_t            wbyte,
    input  logic             tx_pop,
    input  logic             rx_push,
    input  byte_t            rx_byte,
    output byte_t            tx_byte,
    output byte_t            lane0,
    output byte_t            lane1,
    output logic [CNT_W-1:0] tx_cnt,
    output logic [CNT_W-1:0] rx_cnt
);

    localparam int BUF_W = DEPTH * BYTE_W;
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LIM16 = CNT_W'(DEPTH - 2);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
    localparam logic [CNT_W-1:0] ZERO  = '0;

    logic [BUF_W-1:0] buf_q;
    logic [CNT_W-1:0] tx_q, rx_q;
    logic             seq_ok;

    assign seq_ok = (op == OP_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            case (op)
                OP_WR16: begin
                    if (tx_q <= LIM16) begin
                        buf_q <= {buf_q[BUF_W-HALF_W-1:0], wpacked};
                        tx_q  <= tx_q + TWO;
                    end
                end
                OP_WR8: begin
                    if (tx_q < FULL) begin
                        buf_q <= {buf_q[BUF_W-BYTE_W-1:0], wbyte};
                        tx_q  <= tx_q + ONE;
                    end
                end
                OP_RD: begin
                    if (rx_q >= TWO) begin
                        buf_q <= buf_q >> HALF_W;
                        rx_q  <= rx_q - TWO;
                    end else if (rx_q == ONE) begin
                        buf_q <= buf_q >> BYTE_W;
                        rx_q  <= ZERO;
                    end
                end
                default: begin
                    if (tx_pop && tx_q != ZERO)
                        tx_q <= tx_q - ONE;
                    if (rx_push && rx_q != FULL) begin
                        for (int i = 0; i < DEPTH; i++) begin
                            if (CNT_W'(i) == rx_q)
                                buf_q[i*BYTE_W +: BYTE_W] <= rx_byte;
                        end
                        rx_q <= rx_q + ONE;
                    end
                end
            endcase
        end
    end

    // next transmit byte: lane tx_q-1
    always_comb begin
        tx_byte = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i + 1) == tx_q)
                tx_byte = buf_q[i*BYTE_W +: BYTE_W];
        end
    end

    assign lane0  = buf_q[0 +: BYTE_W];
    assign lane1  = buf_q[BYTE_W +: BYTE_W];
    assign tx_cnt = tx_q;
    assign rx_cnt = rx_q;

    // R5
    wr16_full_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WR16 && tx_q > LIM16) |=> $stable(tx_q) && $stable(buf_q));

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_ok && tx_pop && tx_q != ZERO) |=> (tx_q == $past(tx_q) - ONE));

    // R6
    rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_q <= FULL) && (tx_q <= FULL));

    // R12
    host_beats_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD && rx_q == ZERO && rx_push) |=> (rx_q == ZERO));

endmodule

// File: rtl/dpb_flags.sv
module dpb_flags
    import dpb_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  host_op_e         op,
    input  logic             byte_order,
    input  logic             master_mode,
    input  logic             recv_mode,
    input  byte_t            lane0,
    input  byte_t            lane1,
    input  logic [CNT_W-1:0] rx_cnt,
    output half_t            rdata,
    output flag_pulse_t      pulses
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    half_t       rdata_q;
    flag_pulse_t pulse_q, pulse_d;
    logic        is_rd, is_wr;

    assign is_rd = (op == OP_RD);
    assign is_wr = (op == OP_WR16) || (op == OP_WR8);

    always_comb begin
        pulse_d          = '0;
        pulse_d.clr_rrdy = is_rd;
        pulse_d.clr_rovr = is_rd;
        pulse_d.set_ardy = is_rd && master_mode && recv_mode;
        pulse_d.clr_mst  = is_rd && master_mode && recv_mode;
        pulse_d.set_sbd  = is_rd && (rx_cnt == ONE);
        pulse_d.clr_xudf = is_wr;
        pulse_d.clr_xrdy = is_wr;
        pulse_d.kick     = is_rd || is_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            pulse_q <= '0;
        end else begin
            pulse_q <= pulse_d;
            if (is_rd)
                rdata_q <= format_read(lane0, lane1, rx_cnt >= TWO,
                                       rx_cnt == ONE, byte_order);
        end
    end

    assign rdata  = rdata_q;
    assign pulses = pulse_q;

    // R11
    kick_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        (op != OP_IDLE) |=> pulse_q.kick);

    // R11
    kick_single_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> !pulse_q.kick);

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> (pulse_q.clr_rrdy && pulse_q.clr_rovr && !pulse_q.clr_xrdy));

    // R10
    write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        is_wr |=> (pulse_q.clr_xudf && pulse_q.clr_xrdy && !pulse_q.clr_rrdy));

    // R8
    sbd_only_single_chk: assert property (@(posedge clk) disable iff (rst)
        (is_rd && rx_cnt != ONE) |=> !pulse_q.set_sbd);

endmodule

// File: rtl/i2c_dport_buf.sv
module i2c_dport_buf
    import dpb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_order,
    input  logic             master_mode,
    input  logic             recv_mode,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic             host_wr_byte,
    input  logic [15:0]      host_wdata,
    output logic [15:0]      host_rdata,
    input  logic             tx_pop,
    output logic [7:0]       tx_byte,
    output logic [CNT_W-1:0] tx_count,
    input  logic             rx_push,
    input  logic [7:0]       rx_byte,
    output logic [CNT_W-1:0] rx_count,
    output logic             clr_rrdy,
    output logic             clr_rovr,
    output logic             set_ardy,
    output logic             clr_mst,
    output logic             set_sbd,
    output logic             clr_xudf,
    output logic             clr_xrdy,
    output logic             kick
);

    host_op_e    op;
    half_t       wpacked;
    byte_t       lane0, lane1;
    flag_pulse_t pulses;

    assign op      = decode_op(host_rd, host_wr, host_wr_byte);
    assign wpacked = pack_write(host_wdata, byte_order);

    dpb_lanes #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lanes (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .wpacked (wpacked),
        .wbyte   (host_wdata[7:0]),
        .tx_pop  (tx_pop),
        .rx_push (rx_push),
        .rx_byte (rx_byte),
        .tx_byte (tx_byte),
        .lane0   (lane0),
        .lane1   (lane1),
        .tx_cnt  (tx_count),
        .rx_cnt  (rx_count)
    );

    dpb_flags #(.CNT_W(CNT_W)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .byte_order  (byte_order),
        .master_mode (master_mode),
        .recv_mode   (recv_mode),
        .lane0       (lane0),
        .lane1       (lane1),
        .rx_cnt      (rx_count),
        .rdata       (host_rdata),
        .pulses      (pulses)
    );

    assign clr_rrdy = pulses.clr_rrdy;
    assign clr_rovr = pulses.clr_rovr;
    assign set_ardy = pulses.set_ardy;
    assign clr_mst  = pulses.clr_mst;
    assign set_sbd  = pulses.set_sbd;
    assign clr_xudf = pulses.clr_xudf;
    assign clr_xrdy = pulses.clr_xrdy;
    assign kick     = pulses.kick;

    // R8
    sbd_on_single_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && rx_count == CNT_W'(1)) |=> (set_sbd && rx_count == '0));

    // R9
    master_rx_read_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && master_mode && recv_mode) |=> (set_ardy && clr_mst));

endmodule

// File: tb/sim_i2c_dport_buf.sv
`timescale 1ns/100ps
module sim_i2c_dport_buf;

    localparam int DEPTH = 4;
    localparam int CNT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic byte_order = 1'b0, master_mode = 1'b0, recv_mode = 1'b0;
    logic host_rd = 1'b0, host_wr = 1'b0, host_wr_byte = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic tx_pop = 1'b0, rx_push = 1'b0;
    logic [7:0] tx_byte, rx_byte = '0;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic clr_rrdy, clr_rovr, set_ardy, clr_mst, set_sbd, clr_xudf, clr_xrdy, kick;

    int n_chk = 0, n_bad = 0;
    logic [7:0] m [DEPTH];
    int mtx = 0, mrx = 0;

    always #2.5 clk = ~clk;

    i2c_dport_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_counts(input string req);
        chk(tx_count == CNT_W'(mtx), {req, " tx_count"}, int'(tx_count), mtx);
        chk(rx_count == CNT_W'(mrx), {req, " rx_count"}, int'(rx_count), mrx);
        chk(tx_byte == (mtx > 0 ? m[mtx-1] : 8'h00), {req, " tx_byte"},
            int'(tx_byte), mtx > 0 ? int'(m[mtx-1]) : 0);
    endtask

    task automatic shift_up(input int k);
        for (int i = DEPTH - 1; i >= k; i--) m[i] = m[i-k];
    endtask

    task automatic shift_down(input int k);
        for (int i = 0; i < DEPTH; i++) m[i] = (i + k < DEPTH) ? m[i+k] : 8'h00;
    endtask

    task automatic check_write_pulses(input string req);
        chk(clr_xudf && clr_xrdy && !clr_rrdy && !clr_rovr && !set_sbd,
            {req, " write pulses"}, {clr_xudf, clr_xrdy, clr_rrdy}, 3'b110);
        chk(kick, "R11 kick after write", kick, 1);
    endtask

    task automatic write16(input logic [15:0] v, input string req);
        host_wr = 1'b1; host_wr_byte = 1'b0; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        if (mtx <= DEPTH - 2) begin
            shift_up(2);
            m[1] = byte_order ? v[15:8] : v[7:0];
            m[0] = byte_order ? v[7:0] : v[15:8];
            mtx += 2;
        end
        check_write_pulses(req);
        chk_counts(req);
    endtask

    task automatic write8(input logic [7:0] b, input string req);
        host_wr = 1'b1; host_wr_byte = 1'b1; host_wdata = {8'h5A, b};
        @(negedge clk);
        host_wr = 1'b0; host_wr_byte = 1'b0;
        if (mtx < DEPTH) begin
            shift_up(1);
            m[0] = b;
            mtx += 1;
        end
        check_write_pulses(req);
        chk_counts(req);
    endtask

    task automatic pop_one(input string req);
        chk_counts(req);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        if (mtx > 0) mtx -= 1;
        chk(!kick, "R11 no kick on pop", kick, 0);
        chk_counts(req);
    endtask

    task automatic push_one(input logic [7:0] b, input string req);
        rx_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
        if (mrx < DEPTH) begin
            m[mrx] = b;
            mrx += 1;
        end
        chk_counts(req);
    endtask

    task automatic read_one(input logic mm, input logic rm);
        logic [15:0] exp;
        bit sbd;
        master_mode = mm; recv_mode = rm;
        if (mrx >= 2) exp = byte_order ? {m[0], m[1]} : {m[1], m[0]};
        else if (mrx == 1) exp = byte_order ? {m[0], 8'h00} : {8'h00, m[0]};
        else exp = 16'h0000;
        sbd = (mrx == 1);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        if (mrx >= 2) begin shift_down(2); mrx -= 2; end
        else if (mrx == 1) begin shift_down(1); mrx = 0; end
        chk(host_rdata == exp, mrx > 0 || sbd ? "R7/R8 read data" : "R8 empty read data",
            int'(host_rdata), int'(exp));
        chk(set_sbd == sbd, "R8 single-byte flag", set_sbd, sbd);
        chk(clr_rrdy && clr_rovr && !clr_xrdy, "R9 read clears", {clr_rrdy, clr_rovr}, 3);
        chk(set_ardy == (mm && rm) && clr_mst == (mm && rm), "R9 master receive",
            {set_ardy, clr_mst}, (mm && rm) ? 3 : 0);
        chk(kick, "R11 kick after read", kick, 1);
        chk_counts("R7 after read");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(tx_count == 0 && rx_count == 0, "R1 reset counts", {tx_count, rx_count}, 0);
        chk(host_rdata == 0 && tx_byte == 0, "R1 reset data", host_rdata, 0);
        chk({clr_rrdy, clr_rovr, set_ardy, clr_mst, set_sbd, clr_xudf, clr_xrdy, kick} == 0,
            "R1 reset pulses",
            {clr_rrdy, clr_rovr, set_ardy, clr_mst, set_sbd, clr_xudf, clr_xrdy, kick}, 0);

        // R2 R3 R4 R5: transmit packing and drain order
        for (int ord = 0; ord < 2; ord++) begin
            byte_order = ord[0];
            for (int k = 0; k < 4; k++) begin
                write16(16'hA1B2 + 16'(k * 16'h1111), "R2 first half");
                write16(16'h3C4D ^ 16'(k * 16'h0F0F), "R2 second half");
                write16(16'hDEAD, "R5 16-bit write when full");
                write8(8'hEE, "R5 8-bit write when full");
                for (int p = 0; p < 4; p++) pop_one("R3 drain order");
                pop_one("R3 pop at empty");
                write16(16'h1357 + 16'(k), "R2 single half");
                write8(8'h90 + 8'(k), "R4 final byte");
                write16(16'hBEEF, "R5 16-bit with three held");
                write8(8'h60 + 8'(k), "R4 final byte to full");
                for (int p = 0; p < 4; p++) pop_one("R3 drain after byte writes");
            end
        end

        // R6 R7 R8 R9: receive packing, read formatting, every fill level
        for (int ord = 0; ord < 2; ord++) begin
            byte_order = ord[0];
            for (int n = 0; n <= DEPTH + 1; n++) begin
                for (int b = 0; b < n; b++) push_one(8'h11 * 8'(b + 1) + 8'(n), "R6 push");
                for (int r = 0; r < 4; r++) read_one(r[0], r[1]);
            end
        end

        // R12: host access beats sequencer in the same cycle
        byte_order = 1'b1;
        push_one(8'h77, "R6 setup");
        host_rd = 1'b1; rx_push = 1'b1; rx_byte = 8'h99;
        @(negedge clk);
        host_rd = 1'b0; rx_push = 1'b0;
        chk(rx_count == 0, "R12 push ignored during read", rx_count, 0);
        chk(host_rdata == 16'h7700, "R12 read data", host_rdata, 16'h7700);
        mrx = 0;
        write16(16'h1234, "R12 setup");
        host_wr = 1'b1; host_wdata = 16'h5678; tx_pop = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; tx_pop = 1'b0;
        chk(tx_count == 4, "R12 pop ignored during write", tx_count, 4);
        chk(tx_byte == 8'h12, "R12 buffer order", tx_byte, 8'h12);
        host_rd = 1'b1; host_wr = 1'b1; host_wdata = 16'hFFFF;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        chk(tx_count == 4 && clr_rrdy && !clr_xrdy, "R12 read wins over write",
            {tx_count, clr_rrdy, clr_xrdy}, {3'd4, 2'b10});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule